// File: doc/BRIEF.md
# Forced Power-Off Button Emulator

This block lets platform management logic switch the host off by acting as a power button that is held down toward the SoC. A one-cycle request, together with an opaque reason byte, starts the press unless the platform already reports that it is off. Once a press has started, a shutdown-in-progress flag stays set and the button output stays asserted until the platform confirms the shutdown.

Two events count as that confirmation. The first is the power sequencer reporting that the platform sits in S5. The second is the rising edge of the eSPI reset indication while standby power is still good, which means a global reset is under way. Either event releases the button and clears the flag. When a request is accepted, the block sends out a one-cycle report strobe with the reason byte alongside it. The byte is not interpreted, only passed on. The power state machine and the rail enables live outside this block.

Top module: `force_off_ctrl`

## Requirements
- R1: A request (`off_req_i` high for a cycle) while `plat_off_i` is high is ignored: the button output, the busy flag and the report strobe stay low.
- R2: A request while `plat_off_i` is low and the flag is clear sets `btn_press_o` and `off_busy_o` after the next rising clock edge. The same edge drives `rpt_stb_o` high for that one cycle only.
- R3: While the flag is set, `in_s5_i` high clears `btn_press_o` and `off_busy_o` at the next rising edge.
- R4: While the flag is set, a low-to-high change of `espi_rst_i` during a cycle with `stby_pg_i` high clears `btn_press_o` and `off_busy_o` at the next rising edge.
- R5: A rising `espi_rst_i` while the flag is clear, or while `stby_pg_i` is low, leaves `btn_press_o` unchanged.
- R6: `rpt_reason_o` takes the value of `reason_i` from the accepting cycle in the same edge that raises the strobe. It holds that value until the next accepted request.
- R7: A request while the flag is already set produces no strobe, leaves `rpt_reason_o` unchanged and keeps the button asserted.
- R8: Driving `rst_n` low clears the flag, the button and the strobe at once. Release takes effect after `RST_STAGES` rising edges.
- R9: The eSPI release acts on the edge only. An `espi_rst_i` that was already high when the press began does not release it for as long as it stays high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| off_req_i | input | 1 | One-cycle forced shutdown request |
| reason_i | input | REASON_W | Opaque reason byte sampled with the request |
| plat_off_i | input | 1 | Platform already in an off state |
| stby_pg_i | input | 1 | Standby power-good |
| in_s5_i | input | 1 | Power sequencer reports the S5 state |
| espi_rst_i | input | 1 | eSPI reset asserted (active high) |
| btn_press_o | output | 1 | Emulated power button held toward the SoC |
| off_busy_o | output | 1 | Forced shutdown in progress |
| rpt_stb_o | output | 1 | One-cycle reason report strobe |
| rpt_reason_o | output | REASON_W | Reason byte carried with the strobe |

## Verification
The bound checker watches on every cycle how requests, release events and the flag relate: an ignored request while off, the accept with its single-cycle strobe and registered reason, release on S5, release on an eSPI edge with standby power good, and the rule that the flag only rises after a request. Some behaviours need a multi-cycle story, and only the directed scenarios show them. These are a second request during a press that leaves the earlier reason in place, an eSPI level already high when the press begins, an eSPI edge with standby power low, and the immediate clear when reset is asserted in the middle of a press.

// File: rtl/force_off_pkg.sv
package force_off_pkg;

  typedef enum logic [0:0] {
    PRESS_IDLE = 1'b0,
    PRESS_HELD = 1'b1
  } press_state_e;

  typedef struct packed {
    logic req;
    logic plat_off;
    logic s5;
    logic espi_edge;
    logic pgood;
  } press_evt_t;

endpackage

// File: rtl/force_off_rst_sync.sv
module force_off_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/force_off_edge_rise.sv
module force_off_edge_rise (
  input  logic clk,
  input  logic rst_n,
  input  logic level_i,
  output logic rise_o
);
  logic level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
    end else begin
      level_q <= level_i;
    end
  end

  assign rise_o = level_i & ~level_q;
endmodule

// File: rtl/force_off_press_ctl.sv
module force_off_press_ctl
  import force_off_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  press_evt_t evt_i,
  output logic       accept_o,
  output logic       held_o
);
  press_state_e state_q, state_d;
  logic         release_evt;

  assign accept_o    = (state_q == PRESS_IDLE) && evt_i.req && !evt_i.plat_off;
  assign release_evt = evt_i.s5 || (evt_i.espi_edge && evt_i.pgood);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PRESS_IDLE: if (accept_o)    state_d = PRESS_HELD;
      PRESS_HELD: if (release_evt) state_d = PRESS_IDLE;
      default:                     state_d = PRESS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PRESS_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign held_o = (state_q == PRESS_HELD);
endmodule

// File: rtl/force_off_reason_reg.sv
module force_off_reason_reg #(
  parameter int REASON_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load_i,
  input  logic [REASON_W-1:0] reason_i,
  output logic                stb_o,
  output logic [REASON_W-1:0] reason_o
);
  logic                stb_q;
  logic [REASON_W-1:0] reason_q, reason_d;

  always_comb begin
    reason_d = reason_q;
    if (load_i) reason_d = reason_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stb_q    <= 1'b0;
      reason_q <= '0;
    end else begin
      stb_q    <= load_i;
      reason_q <= reason_d;
    end
  end

  assign stb_o    = stb_q;
  assign reason_o = reason_q;
endmodule

// File: rtl/force_off_ctrl.sv
module force_off_ctrl
  import force_off_pkg::*;
#(
  parameter int REASON_W   = 8,
  parameter int RST_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                off_req_i,
  input  logic [REASON_W-1:0] reason_i,
  input  logic                plat_off_i,
  input  logic                stby_pg_i,
  input  logic                in_s5_i,
  input  logic                espi_rst_i,
  output logic                btn_press_o,
  output logic                off_busy_o,
  output logic                rpt_stb_o,
  output logic [REASON_W-1:0] rpt_reason_o
);
  logic       rst_sync_n;
  logic       espi_rise;
  logic       accept;
  logic       held;
  press_evt_t evt;

  force_off_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  force_off_edge_rise u_espi_edge (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .level_i (espi_rst_i),
    .rise_o  (espi_rise)
  );

  assign evt.req       = off_req_i;
  assign evt.plat_off  = plat_off_i;
  assign evt.s5        = in_s5_i;
  assign evt.espi_edge = espi_rise;
  assign evt.pgood     = stby_pg_i;

  force_off_press_ctl u_ctl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .evt_i    (evt),
    .accept_o (accept),
    .held_o   (held)
  );

  force_off_reason_reg #(.REASON_W(REASON_W)) u_reason (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_i   (accept),
    .reason_i (reason_i),
    .stb_o    (rpt_stb_o),
    .reason_o (rpt_reason_o)
  );

  assign btn_press_o = held;
  assign off_busy_o  = held;
endmodule

// File: rtl/force_off_ctrl_chk.sv
module force_off_ctrl_chk #(
  parameter int REASON_W = 8
) (
  input logic                clk,
  input logic                rst_sync_n,
  input logic                off_req_i,
  input logic [REASON_W-1:0] reason_i,
  input logic                plat_off_i,
  input logic                stby_pg_i,
  input logic                in_s5_i,
  input logic                espi_rst_i,
  input logic                btn_press_o,
  input logic                off_busy_o,
  input logic                rpt_stb_o,
  input logic [REASON_W-1:0] rpt_reason_o
);
  assert_ignore_off_R1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (off_req_i && plat_off_i && !off_busy_o) |=> (!off_busy_o && !rpt_stb_o));

  assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (off_req_i && !plat_off_i && !off_busy_o) |=> (btn_press_o && off_busy_o && rpt_stb_o));

  assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rpt_stb_o |=> !rpt_stb_o);

  assert_s5_release_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (off_busy_o && in_s5_i) |=> (!btn_press_o && !off_busy_o));

  assert_espi_release_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (off_busy_o && stby_pg_i && espi_rst_i && !$past(espi_rst_i)) |=> !btn_press_o);

  assert_rise_needs_req_R5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(btn_press_o) |-> ($past(off_req_i) && !$past(plat_off_i)));

  assert_reason_capture_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    rpt_stb_o |-> (rpt_reason_o == $past(reason_i)));

  assert_busy_req_quiet_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (off_busy_o && off_req_i && !in_s5_i && !(espi_rst_i && stby_pg_i)) |=>
      (!rpt_stb_o && $stable(rpt_reason_o) && btn_press_o));
endmodule

bind force_off_ctrl force_off_ctrl_chk #(.REASON_W(REASON_W)) u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .off_req_i    (off_req_i),
  .reason_i     (reason_i),
  .plat_off_i   (plat_off_i),
  .stby_pg_i    (stby_pg_i),
  .in_s5_i      (in_s5_i),
  .espi_rst_i   (espi_rst_i),
  .btn_press_o  (btn_press_o),
  .off_busy_o   (off_busy_o),
  .rpt_stb_o    (rpt_stb_o),
  .rpt_reason_o (rpt_reason_o)
);

// File: tb/force_off_ctrl_bench.sv
`timescale 1ns/1ps
module force_off_ctrl_bench;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          off_req_i, plat_off_i, stby_pg_i, in_s5_i, espi_rst_i;
  logic [RW-1:0] reason_i;
  logic          btn_press_o, off_busy_o, rpt_stb_o;
  logic [RW-1:0] rpt_reason_o;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  force_off_ctrl #(.REASON_W(RW), .RST_STAGES(2)) u_force_off_ctrl (
    .clk(clk), .rst_n(rst_n), .off_req_i(off_req_i), .reason_i(reason_i),
    .plat_off_i(plat_off_i), .stby_pg_i(stby_pg_i), .in_s5_i(in_s5_i),
    .espi_rst_i(espi_rst_i), .btn_press_o(btn_press_o), .off_busy_o(off_busy_o),
    .rpt_stb_o(rpt_stb_o), .rpt_reason_o(rpt_reason_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    off_req_i = 0; plat_off_i = 0; stby_pg_i = 1; in_s5_i = 0; espi_rst_i = 0;
    reason_i = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
  endtask

  task automatic pulse_req(input logic [RW-1:0] r);
    reason_i  = r;
    off_req_i = 1'b1;
    step();
    off_req_i = 1'b0;
    reason_i  = 8'h00;
  endtask

  task automatic t_reset_state();
    do_reset();
    chk("R8 btn after reset", btn_press_o, 0);
    chk("R8 busy after reset", off_busy_o, 0);
    chk("R8 strobe after reset", rpt_stb_o, 0);
  endtask

  task automatic t_ignore_off();
    plat_off_i = 1'b1;
    pulse_req(8'h11);
    chk("R1 btn stays low", btn_press_o, 0);
    chk("R1 no strobe", rpt_stb_o, 0);
    step();
    chk("R1 busy stays low", off_busy_o, 0);
    plat_off_i = 1'b0;
  endtask

  task automatic t_accept();
    pulse_req(8'hA5);
    chk("R2 btn set", btn_press_o, 1);
    chk("R2 busy set", off_busy_o, 1);
    chk("R2 strobe high", rpt_stb_o, 1);
    chk("R6 reason", rpt_reason_o, 8'hA5);
    step();
    chk("R2 strobe one cycle", rpt_stb_o, 0);
    chk("R2 btn held", btn_press_o, 1);
    chk("R6 reason held", rpt_reason_o, 8'hA5);
  endtask

  task automatic t_second_req();
    pulse_req(8'h3C);
    chk("R7 no strobe", rpt_stb_o, 0);
    chk("R7 reason kept", rpt_reason_o, 8'hA5);
    chk("R7 btn kept", btn_press_o, 1);
  endtask

  task automatic t_espi_no_pgood_then_s5();
    stby_pg_i = 1'b0;
    espi_rst_i = 1'b1;
    step();
    chk("R5 espi without pgood keeps btn", btn_press_o, 1);
    espi_rst_i = 1'b0;
    stby_pg_i = 1'b1;
    step();
    in_s5_i = 1'b1;
    step();
    chk("R3 s5 releases btn", btn_press_o, 0);
    chk("R3 s5 clears busy", off_busy_o, 0);
    in_s5_i = 1'b0;
  endtask

  task automatic t_espi_release();
    pulse_req(8'h5A);
    chk("R2 second accept", btn_press_o, 1);
    chk("R6 new reason", rpt_reason_o, 8'h5A);
    step();
    espi_rst_i = 1'b1;
    step();
    chk("R4 espi releases btn", btn_press_o, 0);
    chk("R4 espi clears busy", off_busy_o, 0);
    espi_rst_i = 1'b0;
    step();
  endtask

  task automatic t_espi_idle();
    espi_rst_i = 1'b1;
    step();
    chk("R5 idle espi btn", btn_press_o, 0);
    step();
    chk("R5 idle espi busy", off_busy_o, 0);
    espi_rst_i = 1'b0;
    step();
  endtask

  task automatic t_espi_level_held();
    espi_rst_i = 1'b1;
    step();
    pulse_req(8'h77);
    chk("R9 accept with espi high", btn_press_o, 1);
    repeat (3) step();
    chk("R9 level does not release", btn_press_o, 1);
    espi_rst_i = 1'b0;
    step();
    chk("R9 fall does not release", btn_press_o, 1);
    espi_rst_i = 1'b1;
    step();
    chk("R9 new edge releases", btn_press_o, 0);
    espi_rst_i = 1'b0;
    step();
  endtask

  task automatic t_reset_mid_press();
    pulse_req(8'hC3);
    chk("R8 press before reset", btn_press_o, 1);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R8 async clear btn", btn_press_o, 0);
    chk("R8 async clear busy", off_busy_o, 0);
    step();
    rst_n = 1'b1;
    step();
    off_req_i = 1'b1;
    step();
    off_req_i = 1'b0;
    chk("R8 request during release ignored", btn_press_o, 0);
    repeat (2) step();
    pulse_req(8'h01);
    chk("R8 works after release", btn_press_o, 1);
  endtask

  initial begin
    #50000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset_state();
    t_ignore_off();
    t_accept();
    t_second_req();
    t_espi_no_pgood_then_s5();
    t_espi_release();
    t_espi_idle();
    t_espi_level_held();
    t_reset_mid_press();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule